// File: doc/BRIEF.md
# Three-Wire-Plus-Select Serial EEPROM Model

This block behaves as a small serial EEPROM of 64 words, 16 bits each, reached over four wires: a chip select, a serial clock, a serial data input and a serial data output. The serial clock is sampled with the system clock, and a rising serial-clock edge is detected as one interface clock. While chip select is high, the block waits for a start bit of 1. It then takes in a two-bit opcode and a six-bit address, most significant bit first, and carries out the command on its internal word array.

Read data goes out on the output pin: first a zero, then the addressed word from bit 15 down to bit 0. Programming commands are write one word, erase one word, erase every word and write every word. They take effect only after a write-enable command has set an internal latch, and a write-disable command clears that latch. A command that is still incomplete when chip select falls is thrown away. Programming completes on the last bit, with no busy period.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset, dout is 0, every word reads back 16'hFFFF and programming is disabled.
- R2: Opcode 10 (read) makes dout 0 on the rising serial-clock edge that carries the last address bit. Each of the next 16 rising edges then puts one bit of the addressed word on dout, bit 15 first.
- R3: Opcode 01 (write) with programming enabled stores the 16 data bits that follow the address, MSB first, into the addressed word. The store happens on the last data bit.
- R4: Opcode 11 (erase) with programming enabled sets the addressed word to 16'hFFFF.
- R5: Opcode 00 with address bits [5:4] = 11 enables programming, and 00 with [5:4] = 00 disables it. While programming is disabled, write, erase, erase-all and write-all leave the array unchanged.
- R6: Opcode 00 with address bits [5:4] = 10 and programming enabled sets every word to 16'hFFFF.
- R7: Opcode 00 with address bits [5:4] = 01 and programming enabled writes the 16 following data bits to every word.
- R8: A low chip select returns the decoder to waiting for a start bit and forces dout to 0. A write cut short this way changes nothing.
- R9: Zero bits clocked in before the start bit are ignored. For opcode 00, address bits [3:0] do not matter.
- R10: While chip select is high, dout changes only on a rising serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial interface |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; a rising edge shifts one bit |
| di | input | 1 | Serial data into the block |
| dout | output | 1 | Serial data out of the block |

## Verification
The assertions assume that sk stays at each level for at least one system clock. They also assume that cs and di change only while sk is low, so that every rising sk edge is seen once and carries stable data. The bench meets this by changing inputs only on falling system-clock edges and by holding each sk phase for two system clocks. It raises or drops cs only while sk is low.

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  localparam int WORDS = 1 << AW;
  localparam int HW = AW + 2;
  localparam int CW = $clog2(DW) + 1;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_READ, S_DONE} st_t;

  st_t st;
  logic sk_q, wen, all_w;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sr, rdw;
  logic [AW-1:0] addr;
  logic [DW-1:0] mem [WORDS];

  wire rise = sk & ~sk_q;
  wire [HW-1:0] hdr  = {sr[HW-2:0], di};
  wire [DW-1:0] word = {sr[DW-2:0], di};
  wire [1:0] op  = hdr[HW-1:HW-2];
  wire [AW-1:0] a = hdr[AW-1:0];
  wire [1:0] sub = a[AW-1:AW-2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sk_q <= 1'b0;
      wen <= 1'b0;
      all_w <= 1'b0;
      cnt <= '0;
      sr <= '0;
      rdw <= '0;
      addr <= '0;
      dout <= 1'b0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      sk_q <= sk;
      if (!cs) begin
        st <= S_IDLE;
        dout <= 1'b0;
      end else if (rise) begin
        case (st)
          S_IDLE: if (di) begin
            st <= S_HDR;
            cnt <= '0;
          end
          S_HDR: begin
            sr <= {sr[DW-2:0], di};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HW - 1)) begin
              cnt <= '0;
              addr <= a;
              all_w <= 1'b0;
              st <= S_DONE;
              case (op)
                2'b10: begin
                  rdw <= mem[a];
                  dout <= 1'b0;
                  st <= S_READ;
                end
                2'b01: st <= S_DATA;
                2'b11: if (wen) mem[a] <= '1;
                default: case (sub)
                  2'b11: wen <= 1'b1;
                  2'b00: wen <= 1'b0;
                  2'b10: if (wen) for (int i = 0; i < WORDS; i++) mem[i] <= '1;
                  default: begin
                    all_w <= 1'b1;
                    st <= S_DATA;
                  end
                endcase
              endcase
            end
          end
          S_DATA: begin
            sr <= {sr[DW-2:0], di};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW - 1)) begin
              st <= S_DONE;
              if (wen) begin
                if (all_w) for (int i = 0; i < WORDS; i++) mem[i] <= word;
                else mem[addr] <= word;
              end
            end
          end
          S_READ: begin
            dout <= rdw[DW-1];
            rdw <= {rdw[DW-2:0], 1'b0};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW - 1)) st <= S_DONE;
          end
          default: dout <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sk,
  input logic dout,
  input logic wen
);
  logic skp;
  always_ff @(posedge clk) skp <= sk;

  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !dout);

  p_edge_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !(sk && !skp)) |=> $stable(dout));

  p_wen_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(wen));

  p_wen_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !wen);
endmodule

bind uwire_eeprom uwire_eeprom_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .dout(dout), .wen(wen)
);

// File: tb/test_uwire_eeprom.sv
module test_uwire_eeprom;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uwire_eeprom i_uwire_eeprom (.clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout));

  // {kind[1:0], op[1:0], addr[5:0], data_or_expected[15:0], req[3:0]}
  // kind 0: command without data, 1: command with 16 data bits, 2: read and compare
  localparam int NV = 27;
  localparam logic [29:0] VEC [NV] = '{
    {2'd1, 2'b01, 6'd3,  16'h1234, 4'd5},  // R5 write while disabled
    {2'd2, 2'b10, 6'd3,  16'hFFFF, 4'd5},
    {2'd0, 2'b00, 6'h35, 16'h0000, 4'd5},  // R5 enable, R9 low bits 0101
    {2'd1, 2'b01, 6'd3,  16'h1234, 4'd3},  // R3
    {2'd2, 2'b10, 6'd3,  16'h1234, 4'd3},
    {2'd1, 2'b01, 6'd0,  16'hA5C3, 4'd3},
    {2'd2, 2'b10, 6'd0,  16'hA5C3, 4'd3},
    {2'd1, 2'b01, 6'd63, 16'h8001, 4'd3},
    {2'd2, 2'b10, 6'd63, 16'h8001, 4'd3},
    {2'd2, 2'b10, 6'd3,  16'h1234, 4'd3},
    {2'd0, 2'b11, 6'd3,  16'h0000, 4'd4},  // R4
    {2'd2, 2'b10, 6'd3,  16'hFFFF, 4'd4},
    {2'd2, 2'b10, 6'd0,  16'hA5C3, 4'd4},
    {2'd1, 2'b00, 6'h1A, 16'h5A5A, 4'd7},  // R7
    {2'd2, 2'b10, 6'd17, 16'h5A5A, 4'd7},
    {2'd2, 2'b10, 6'd63, 16'h5A5A, 4'd7},
    {2'd0, 2'b00, 6'h27, 16'h0000, 4'd6},  // R6
    {2'd2, 2'b10, 6'd40, 16'hFFFF, 4'd6},
    {2'd2, 2'b10, 6'd0,  16'hFFFF, 4'd6},
    {2'd1, 2'b01, 6'd9,  16'h0F0F, 4'd3},
    {2'd0, 2'b00, 6'h0C, 16'h0000, 4'd5},  // R5 disable, R9 low bits 1100
    {2'd1, 2'b01, 6'd9,  16'h1111, 4'd5},
    {2'd2, 2'b10, 6'd9,  16'h0F0F, 4'd5},
    {2'd0, 2'b11, 6'd9,  16'h0000, 4'd5},
    {2'd0, 2'b00, 6'h20, 16'h0000, 4'd5},
    {2'd1, 2'b00, 6'h10, 16'h7777, 4'd5},
    {2'd2, 2'b10, 6'd9,  16'h0F0F, 4'd5}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic o);
    di = b;
    @(negedge clk);
    sk = 1'b1;
    repeat (2) @(negedge clk);
    o = dout;
    sk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic header(input int lead, input logic [1:0] op, input logic [5:0] a, output logic last);
    logic o;
    cs = 1'b1;
    @(negedge clk);
    for (int i = 0; i < lead; i++) bit_io(1'b0, o);
    bit_io(1'b1, o);
    bit_io(op[1], o);
    bit_io(op[0], o);
    for (int i = 5; i >= 0; i--) bit_io(a[i], last);
  endtask

  task automatic release_cs();
    cs = 1'b0;
    di = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [5:0] a, input bit has_data, input logic [15:0] d);
    logic o;
    header(0, op, a, o);
    if (has_data) for (int i = 15; i >= 0; i--) bit_io(d[i], o);
    release_cs();
  endtask

  task automatic rd(input int lead, input logic [5:0] a, output logic [15:0] v, output logic dummy);
    logic o;
    header(lead, 2'b10, a, dummy);
    for (int i = 15; i >= 0; i--) begin
      bit_io(1'b0, o);
      v[i] = o;
    end
    release_cs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic dz, o;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dout at reset", {15'd0, dout}, 16'h0000);
    rd(0, 6'd5, v, dz);
    check("R1 word 5 after reset", v, 16'hFFFF);
    check("R2 dummy zero", {15'd0, dz}, 16'h0000);
    rd(0, 6'd63, v, dz);
    check("R1 word 63 after reset", v, 16'hFFFF);

    for (int n = 0; n < NV; n++) begin
      logic [29:0] e;
      e = VEC[n];
      if (e[29:28] == 2'd2) begin
        rd(0, e[25:20], v, dz);
        checks++;
        if (v !== e[19:4]) begin
          fails++;
          $display("FAIL R%0d vector %0d: actual %h expected %h", e[3:0], n, v, e[19:4]);
        end
      end else begin
        cmd(e[27:26], e[25:20], e[29:28] == 2'd1, e[19:4]);
      end
    end

    // R2: a word with bit 15 set still gets a leading zero, then MSB first
    cmd(2'b00, 6'h30, 1'b0, 16'h0);
    cmd(2'b01, 6'd21, 1'b1, 16'hC001);
    rd(0, 6'd21, v, dz);
    check("R2 dummy before MSB=1 word", {15'd0, dz}, 16'h0000);
    check("R2 read word 21", v, 16'hC001);

    // R8: write cut short by chip select
    header(0, 2'b01, 6'd2, o);
    for (int i = 0; i < 8; i++) bit_io(1'b0, o);
    release_cs();
    check("R8 dout low after abort", {15'd0, dout}, 16'h0000);
    rd(0, 6'd2, v, dz);
    check("R8 aborted write discarded", v, 16'hFFFF);

    // R8: chip select dropped mid read forces dout low
    header(0, 2'b10, 6'd21, o);
    bit_io(1'b0, o);
    check("R8 bit 15 before drop", {15'd0, o}, 16'h0001);
    release_cs();
    check("R8 dout low after read abort", {15'd0, dout}, 16'h0000);

    // R9: leading zeros before the start bit
    rd(3, 6'd21, v, dz);
    check("R9 read with leading zeros", v, 16'hC001);

    // R10: dout holds through long serial-clock phases
    header(0, 2'b10, 6'd21, o);
    repeat (6) @(negedge clk);
    check("R10 dummy held while sk low", {15'd0, dout}, 16'h0000);
    sk = 1'b1;
    repeat (8) @(negedge clk);
    check("R10 bit 15 held while sk high", {15'd0, dout}, 16'h0001);
    sk = 1'b0;
    repeat (8) @(negedge clk);
    check("R10 bit 15 held while sk low", {15'd0, dout}, 16'h0001);
    release_cs();

    // R1: reset again restores erased array and disables programming
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmd(2'b01, 6'd21, 1'b1, 16'h0000);
    rd(0, 6'd21, v, dz);
    check("R1 erased and disabled after reset", v, 16'hFFFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule